// File: doc/BRIEF.md
# Superimpose Key Generator

This block decides, for every dot of the picture, whether the graphics layer is shown over an external video source or left transparent. Each dot clock it receives the 12-bit colour of the current pixel, the 12-bit border colour and a 12-bit key colour. It also receives an overlay enable, a 2-bit keying mode, a fallback level bit and a blanking flag. From these it forms a one-bit overlay key: 1 shows the graphics and 0 makes them transparent.

The key can follow one of three rules. It can mark every pixel that differs from a black border. It can mark every pixel that differs from a programmable key colour. Or it can hold the whole screen at a fixed fallback level. The pixel path downstream has its own pipeline, so the key then passes through a delay line whose length, 0 to 31 dot clocks, is set by a 5-bit phase input. This lets the key line up with the video it controls.

Top module: `sikey_top`

## Requirements
- R1: While `key_en` is low, the key for that pixel is 0.
- R2: With `key_mode` = 2'b00 (no comparison), `key_en` high and `blank` low, the key equals `fallback_lvl`.
- R3: With `key_mode` = 2'b01 (reserved), `key_en` high and `blank` low, the key equals `fallback_lvl`.
- R4: With `key_mode` = 2'b10 and `border_color` = 12'h000, the key is 1 when `pix_color` differs from `border_color` in any of its 12 bits, and 0 when they are equal.
- R5: With `key_mode` = 2'b10 and a non-zero `border_color`, the compare condition is not met and the key equals `fallback_lvl`.
- R6: With `key_mode` = 2'b11, the key is 1 when `pix_color` differs from `ckey_color` (exact 12-bit comparison), and 0 when they are equal.
- R7: While `blank` is high, the key for that pixel is 0, whatever the mode and the enable.
- R8: The inputs of a dot sampled at clock edge k appear on `ys_out` right after edge k+1+`phase_dly`. The phase input selects the tap at the output edge.
- R9: While `rst` is high, `ys_out` is 0 from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| key_en | input | 1 | Overlay enable; low forces the key to 0 |
| key_mode | input | 2 | 00 none, 01 reserved, 10 border keying, 11 colour keying |
| fallback_lvl | input | 1 | Full-screen level used when no comparison applies |
| blank | input | 1 | Blanking interval of the current dot |
| phase_dly | input | 5 | Extra dot-clock delay of the key, 0 to 31 |
| pix_color | input | 12 | Colour of the current pixel |
| border_color | input | 12 | Border colour |
| ckey_color | input | 12 | Key colour for colour keying |
| ys_out | output | 1 | Registered overlay key, 1 = show graphics |

## Verification
The key for a dot's inputs is due 2 + `phase_dly` clock edges after those inputs are sampled: one edge for the decision register and 1 + `phase_dly` edges through the delay line and the output register. The bench samples on falling edges and keeps a 64-entry ring of the expected key and its requirement tag, indexed by the edge at which the inputs were taken. It compares `ys_out` with the entry 1 + `phase_dly` edges back. After every change of `phase_dly` it waits until the whole line has refilled under the new setting before it checks again.

// File: rtl/sikey_pkg.sv
package sikey_pkg;
  typedef enum logic [1:0] {
    KEY_NONE   = 2'b00,
    KEY_RSVD   = 2'b01,
    KEY_BORDER = 2'b10,
    KEY_CHROMA = 2'b11
  } key_mode_e;
endpackage

// File: rtl/sikey_decide.sv
module sikey_decide
  import sikey_pkg::*;
#(
  parameter int COLOR_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_en,
  input  logic [1:0]         key_mode,
  input  logic               fallback_lvl,
  input  logic               blank,
  input  logic [COLOR_W-1:0] pix_color,
  input  logic [COLOR_W-1:0] border_color,
  input  logic [COLOR_W-1:0] ckey_color,
  output logic               dec_q
);
  logic      pix_ne_border;
  logic      pix_ne_ckey;
  logic      border_black;
  logic      dec_d;
  key_mode_e mode;

  assign mode          = key_mode_e'(key_mode);
  assign pix_ne_border = (pix_color != border_color);
  assign pix_ne_ckey   = (pix_color != ckey_color);
  assign border_black  = (border_color == '0);

  always_comb begin
    dec_d = fallback_lvl;
    unique case (mode)
      KEY_BORDER: if (border_black) dec_d = pix_ne_border;
      KEY_CHROMA: dec_d = pix_ne_ckey;
      default:    dec_d = fallback_lvl;
    endcase
    if (!key_en || blank) dec_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) dec_q <= 1'b0;
    else     dec_q <= dec_d;
  end
endmodule

// File: rtl/sikey_delay.sv
module sikey_delay #(
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);
  localparam int TAPS = 1 << SEL_W;

  logic [TAPS-2:0] line_q;
  logic [TAPS-1:0] taps;

  assign taps = {line_q, din};

  generate
    if (TAPS > 2) begin : g_long
      always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= {line_q[TAPS-3:0], din};
      end
    end else begin : g_short
      always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= din;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dout <= 1'b0;
    else     dout <= taps[sel];
  end
endmodule

// File: rtl/sikey_top.sv
module sikey_top #(
  parameter int COLOR_W = 12,
  parameter int PHASE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_en,
  input  logic [1:0]         key_mode,
  input  logic               fallback_lvl,
  input  logic               blank,
  input  logic [PHASE_W-1:0] phase_dly,
  input  logic [COLOR_W-1:0] pix_color,
  input  logic [COLOR_W-1:0] border_color,
  input  logic [COLOR_W-1:0] ckey_color,
  output logic               ys_out
);
  logic dec_q;

  sikey_decide #(.COLOR_W(COLOR_W)) decide_i (
    .clk          (clk),
    .rst          (rst),
    .key_en       (key_en),
    .key_mode     (key_mode),
    .fallback_lvl (fallback_lvl),
    .blank        (blank),
    .pix_color    (pix_color),
    .border_color (border_color),
    .ckey_color   (ckey_color),
    .dec_q        (dec_q)
  );

  sikey_delay #(.SEL_W(PHASE_W)) delay_i (
    .clk  (clk),
    .rst  (rst),
    .din  (dec_q),
    .sel  (phase_dly),
    .dout (ys_out)
  );
endmodule

// File: rtl/sikey_chk.sv
module sikey_chk #(
  parameter int COLOR_W = 12,
  parameter int PHASE_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               key_en,
  input logic [1:0]         key_mode,
  input logic               fallback_lvl,
  input logic               blank,
  input logic [PHASE_W-1:0] phase_dly,
  input logic [COLOR_W-1:0] pix_color,
  input logic [COLOR_W-1:0] border_color,
  input logic [COLOR_W-1:0] ckey_color,
  input logic               dec_q,
  input logic               ys_out
);
  p_off_r1: assert property (@(posedge clk) disable iff (rst)
    !key_en |=> !dec_q);

  p_fallback_r2: assert property (@(posedge clk) disable iff (rst)
    (key_en && !blank && key_mode == 2'b00) |=> (dec_q == $past(fallback_lvl)));

  p_border_r4: assert property (@(posedge clk) disable iff (rst)
    (key_en && !blank && key_mode == 2'b10 && border_color == '0)
      |=> (dec_q == ($past(pix_color) != '0)));

  p_border_fb_r5: assert property (@(posedge clk) disable iff (rst)
    (key_en && !blank && key_mode == 2'b10 && border_color != '0)
      |=> (dec_q == $past(fallback_lvl)));

  p_chroma_r6: assert property (@(posedge clk) disable iff (rst)
    (key_en && !blank && key_mode == 2'b11)
      |=> (dec_q == ($past(pix_color) != $past(ckey_color))));

  p_blank_r7: assert property (@(posedge clk) disable iff (rst)
    blank |=> !dec_q);

  p_phase0_r8: assert property (@(posedge clk) disable iff (rst)
    (phase_dly == '0) |=> (ys_out == $past(dec_q)));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> !ys_out);
endmodule

bind sikey_top sikey_chk #(.COLOR_W(COLOR_W), .PHASE_W(PHASE_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .key_en       (key_en),
  .key_mode     (key_mode),
  .fallback_lvl (fallback_lvl),
  .blank        (blank),
  .phase_dly    (phase_dly),
  .pix_color    (pix_color),
  .border_color (border_color),
  .ckey_color   (ckey_color),
  .dec_q        (dec_q),
  .ys_out       (ys_out)
);

// File: tb/sikey_tb.sv
module sikey_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        key_en = 1'b0;
  logic [1:0]  key_mode = 2'b00;
  logic        fallback_lvl = 1'b0;
  logic        blank = 1'b0;
  logic [4:0]  phase_dly = 5'd0;
  logic [11:0] pix_color = '0;
  logic [11:0] border_color = '0;
  logic [11:0] ckey_color = '0;
  logic        ys_out;

  int checks = 0;
  int errors = 0;
  int edge_cnt = 0;
  int settle = 0;
  bit done = 0;
  bit        exp_hist [64];
  string     tag_hist [64];

  always #10 clk = ~clk;
  always @(posedge clk) edge_cnt++;

  sikey_top dut_i (
    .clk(clk), .rst(rst), .key_en(key_en), .key_mode(key_mode),
    .fallback_lvl(fallback_lvl), .blank(blank), .phase_dly(phase_dly),
    .pix_color(pix_color), .border_color(border_color),
    .ckey_color(ckey_color), .ys_out(ys_out)
  );

  function automatic bit model_key(bit en, bit [1:0] md, bit fb, bit bl,
                                   bit [11:0] px, bit [11:0] bd, bit [11:0] ck);
    if (bl || !en) return 1'b0;
    case (md)
      2'b10:   return (bd == 12'h000) ? (px != bd) : fb;
      2'b11:   return px != ck;
      default: return fb;
    endcase
  endfunction

  function automatic string model_tag(bit en, bit [1:0] md, bit bl, bit [11:0] bd);
    if (bl) return "R7";
    if (!en) return "R1";
    case (md)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return (bd == 12'h000) ? "R4" : "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ys_out=%0b expected %0b (phase %0d, edge %0d)",
               tag, act, exp, phase_dly, edge_cnt);
    end
  endtask

  // One dot: check the output due now, then drive the next inputs.
  task automatic step(bit en, bit [1:0] md, bit fb, bit bl,
                      bit [11:0] px, bit [11:0] bd, bit [11:0] ck);
    int idx;
    @(negedge clk);
    if (settle > int'(phase_dly) + 2) begin
      // R8: inputs sampled at edge k show after edge k+1+phase
      idx = (edge_cnt - 1 - int'(phase_dly)) & 63;
      check({tag_hist[idx], "/R8"}, ys_out, exp_hist[idx]);
    end
    key_en = en; key_mode = md; fallback_lvl = fb; blank = bl;
    pix_color = px; border_color = bd; ckey_color = ck;
    idx = (edge_cnt + 1) & 63;
    exp_hist[idx] = model_key(en, md, fb, bl, px, bd, ck);
    tag_hist[idx] = model_tag(en, md, bl, bd);
    settle++;
  endtask

  task automatic set_phase(bit [4:0] ph);
    @(negedge clk);
    phase_dly = ph;
    settle = 0;
  endtask

  task automatic rand_segment(int n, bit [1:0] md, bit [11:0] bd);
    for (int i = 0; i < n; i++) begin
      bit [11:0] ck = 12'h5A3;
      bit [11:0] px = 12'($urandom);
      bit [1:0]  sel = 2'($urandom);
      if (sel == 0) px = ck;
      if (sel == 1) px = bd;
      step(($urandom % 8) != 0, md, 1'($urandom), ($urandom % 10) == 0,
           px, bd, ck);
    end
  endtask

  initial begin
    bit [4:0] ph;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin
      exp_hist[i] = 1'b0;
      tag_hist[i] = "R9";
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", ys_out, 1'b0); // reset state
    rst = 1'b0;

    // R2 R3: fallback levels, phase 0
    set_phase(5'd0);
    for (int i = 0; i < 8; i++) step(1, 2'b00, i[0], 0, 12'h123, 12'h000, 12'h456);
    for (int i = 0; i < 8; i++) step(1, 2'b01, i[1], 0, 12'h000, 12'h000, 12'h000);
    // R4: black border, match and mismatch incl. single-bit difference
    step(1, 2'b10, 0, 0, 12'h000, 12'h000, 12'h000);
    step(1, 2'b10, 1, 0, 12'h800, 12'h000, 12'h000);
    step(1, 2'b10, 1, 0, 12'h001, 12'h000, 12'h000);
    // R5: non-black border falls back
    step(1, 2'b10, 1, 0, 12'h00F, 12'h00F, 12'h000);
    step(1, 2'b10, 0, 0, 12'h123, 12'h00F, 12'h000);
    // R6: colour key exact match and top-bit mismatch
    step(1, 2'b11, 1, 0, 12'hABC, 12'h000, 12'hABC);
    step(1, 2'b11, 0, 0, 12'h2BC, 12'h000, 12'hABC);
    // R7 and R1
    step(1, 2'b11, 1, 1, 12'h111, 12'h000, 12'h222);
    step(0, 2'b00, 1, 0, 12'h111, 12'h000, 12'h222);
    rand_segment(40, 2'b11, 12'h000);

    // R8: longest delay
    set_phase(5'd31);
    rand_segment(120, 2'b10, 12'h000);
    rand_segment(60, 2'b10, 12'h030);
    // R8: intermediate delays
    for (int s = 0; s < 6; s++) begin
      ph = 5'($urandom);
      set_phase(ph);
      rand_segment(80, 2'($urandom), ($urandom % 2) ? 12'h000 : 12'($urandom));
    end
    set_phase(5'd5);
    rand_segment(60, 2'b01, 12'h000);

    // R9: reset clears output mid-stream
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9", ys_out, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule